// File: doc/BRIEF.md
# Eight-Channel Periodic Interrupt Timer

This block holds eight independent 16-bit down-counters behind a byte-wide register port. Each counter takes its decrement ticks from one of two shared prescalers, chosen per channel. A channel that reaches zero on a tick does three things: it reloads from its own load register, it sets its time-out flag, and it drives its interrupt line if that channel's interrupt enable is set. Software can also push the load value into a running counter at any moment through a write-one force strobe.

Nothing runs without a module enable bit. While that bit is clear the prescalers and counters freeze and no flag can be set. A channel becomes live when both the module enable and its own channel enable are set. On that rising edge of "live" the channel copies its load register into its counter. Clearing a channel enable also drops that channel's pending flag.

Register map (byte addresses, each bit i belongs to channel i):

- 0x00: module enable, in bit 0.
- 0x01: force strobes. This register always reads as zero.
- 0x02: channel enables.
- 0x03: time-base selects. A bit value of 0 picks prescaler 0 and 1 picks prescaler 1.
- 0x04: interrupt enables.
- 0x05: time-out flags, cleared by writing one.
- 0x06 and 0x07: reload values for prescaler 0 and prescaler 1.
- 0x08+2i and 0x09+2i: low and high byte of channel i's load register.
- 0x18+2i and 0x19+2i: low and high byte of channel i's live count, read-only.

Top module: `pit_timer_top`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low.
- R2: The channel-enable register at 0x02 and the time-base select register at 0x03 read back the byte last written to them.
- R3: When a channel becomes live (module enable and channel enable both set), its counter holds the load value one clock later. After that it decreases by one on each tick of the prescaler it has selected.
- R4: A tick that finds a live counter at zero reloads the counter from its load register and sets that channel's flag (bit i of 0x05). The reload period is therefore load+1 ticks.
- R5: A prescaler with reload value P produces one tick every P+1 clocks while the module is enabled. A channel with select bit 0 counts prescaler 0 ticks, and a channel with select bit 1 counts prescaler 1 ticks.
- R6: Writing a one to bit i of 0x01 copies load register i into counter i on that write's clock edge. Bits written as zero leave their counters untouched.
- R7: A force write is ignored when the channel enable or the module enable is clear.
- R8: Register 0x01 always reads zero.
- R9: Clearing a channel enable clears that channel's flag, and the flag stays clear while the channel is disabled.
- R10: Writing one to a flag bit clears it. If a time-out for that channel occurs on the same edge as the clear, the flag stays set.
- R11: Interrupt output i is high exactly when flag i and interrupt enable i (bit i of 0x04) are both set.
- R12: While the module enable is clear, counters and prescalers hold their values and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte write |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt requests |

## Verification
The bench uses the default parameters: eight channels, 16-bit counters and 8-bit prescalers. Prescaler 0 is programmed to reload 0, so it ticks on every clock. That lets the bench predict each counter value cycle by cycle and reach the wrap, the force load and a set-versus-clear collision within a few clocks. Prescaler 1 is programmed to reload 3. Two channels with large load values, one on each time base, are then compared over a 40-clock window to confirm the 4:1 rate difference, and frozen to confirm that counting holds while the module enable is clear.

// File: rtl/pit_pkg.sv
package pit_pkg;
  timeunit 1ns; timeprecision 10ps;
  localparam int unsigned REG_AW = 6;
  localparam logic [REG_AW-1:0] A_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] A_FORCE = 6'h01;
  localparam logic [REG_AW-1:0] A_CHEN  = 6'h02;
  localparam logic [REG_AW-1:0] A_TBSEL = 6'h03;
  localparam logic [REG_AW-1:0] A_IRQEN = 6'h04;
  localparam logic [REG_AW-1:0] A_FLAGS = 6'h05;
  localparam logic [REG_AW-1:0] A_PRE0  = 6'h06;
  localparam logic [REG_AW-1:0] A_PRE1  = 6'h07;
  localparam logic [REG_AW-1:0] A_LOAD  = 6'h08;
  localparam logic [REG_AW-1:0] A_CNT   = 6'h18;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PRE_W-1:0] reload_i,
  output logic             tick_o
);
  timeunit 1ns; timeprecision 10ps;

  logic [PRE_W-1:0] cnt_q, cnt_n;

  assign tick_o = en_i && (cnt_q == '0);

  always_comb begin
    cnt_n = tick_o ? reload_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_n;
    end
  end

  AST_PRE_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && reload_i != '0) |=> !tick_o); // R5
  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o
);
  timeunit 1ns; timeprecision 10ps;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             start, wrap, cnt_en;

  assign start     = run_i & ~run_q;
  assign wrap      = run_i & run_q & ~force_i & tick_i & (cnt_q == '0);
  assign cnt_en    = run_i & (start | force_i | tick_i);
  assign timeout_o = wrap;
  assign cnt_o     = cnt_q;

  always_comb begin
    cnt_n = cnt_q;
    if (start || force_i) begin
      cnt_n = load_i;
    end else if (wrap) begin
      cnt_n = load_i;
    end else if (tick_i) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_i;
      if (cnt_en) begin
        cnt_q <= cnt_n;
      end
    end
  end

  AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q)); // R12
  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && run_q && !force_i && tick_i && cnt_q == '0) |=> (cnt_q == $past(load_i))); // R4
  AST_FORCE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && force_i) |=> (cnt_q == $past(load_i))); // R6
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [REG_AW-1:0]         addr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  input  logic [NCH-1:0][CNT_W-1:0] cnt_i,
  input  logic [NCH-1:0]            timeout_i,
  output logic                      men_o,
  output logic [NCH-1:0]            chen_o,
  output logic [NCH-1:0]            tbsel_o,
  output logic [NCH-1:0]            irqen_o,
  output logic [1:0][PRE_W-1:0]     pre_rl_o,
  output logic [NCH-1:0][CNT_W-1:0] load_o,
  output logic [NCH-1:0]            force_o,
  output logic [NCH-1:0]            flag_o
);
  timeunit 1ns; timeprecision 10ps;

  localparam int unsigned HI_W = CNT_W - 8;

  logic                  men_q, men_n;
  logic [NCH-1:0]        chen_q, chen_n, tbsel_q, tbsel_n, irqen_q, irqen_n;
  logic [NCH-1:0]        flag_q, flag_n, flag_clr;
  logic [1:0][PRE_W-1:0] pre_q, pre_n;
  logic [7:0]            rdata_n;

  always_comb begin
    men_n   = men_q;
    chen_n  = chen_q;
    tbsel_n = tbsel_q;
    irqen_n = irqen_q;
    pre_n   = pre_q;
    if (wr_i) begin
      case (addr_i)
        A_CTRL:  men_n    = wdata_i[0];
        A_CHEN:  chen_n   = wdata_i[NCH-1:0];
        A_TBSEL: tbsel_n  = wdata_i[NCH-1:0];
        A_IRQEN: irqen_n  = wdata_i[NCH-1:0];
        A_PRE0:  pre_n[0] = wdata_i[PRE_W-1:0];
        A_PRE1:  pre_n[1] = wdata_i[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  assign force_o  = (wr_i && addr_i == A_FORCE) ? wdata_i[NCH-1:0] : '0;
  assign flag_clr = (wr_i && addr_i == A_FLAGS) ? wdata_i[NCH-1:0] : '0;
  assign flag_n   = chen_q & ((flag_q & ~flag_clr) | timeout_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q   <= 1'b0;
      chen_q  <= '0;
      tbsel_q <= '0;
      irqen_q <= '0;
      pre_q   <= '0;
      flag_q  <= '0;
    end else begin
      men_q   <= men_n;
      chen_q  <= chen_n;
      tbsel_q <= tbsel_n;
      irqen_q <= irqen_n;
      pre_q   <= pre_n;
      flag_q  <= flag_n;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_load
    localparam logic [REG_AW-1:0] LO_A = A_LOAD + REG_AW'(2 * g);
    localparam logic [REG_AW-1:0] HI_A = A_LOAD + REG_AW'(2 * g + 1);
    logic [CNT_W-1:0] ld_q, ld_n;
    logic             wlo, whi;
    assign wlo = wr_i && (addr_i == LO_A);
    assign whi = wr_i && (addr_i == HI_A);
    always_comb begin
      ld_n = ld_q;
      if (wlo) ld_n[7:0] = wdata_i;
      if (whi) ld_n[CNT_W-1:8] = wdata_i[HI_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ld_q <= '0;
      end else if (wlo || whi) begin
        ld_q <= ld_n;
      end
    end
    assign load_o[g] = ld_q;
  end

  always_comb begin
    rdata_n = '0;
    case (addr_i)
      A_CTRL:  rdata_n[0]       = men_q;
      A_CHEN:  rdata_n[NCH-1:0] = chen_q;
      A_TBSEL: rdata_n[NCH-1:0] = tbsel_q;
      A_IRQEN: rdata_n[NCH-1:0] = irqen_q;
      A_FLAGS: rdata_n[NCH-1:0] = flag_q;
      A_PRE0:  rdata_n[PRE_W-1:0] = pre_q[0];
      A_PRE1:  rdata_n[PRE_W-1:0] = pre_q[1];
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == A_LOAD + REG_AW'(2 * i))     rdata_n = load_o[i][7:0];
      if (addr_i == A_LOAD + REG_AW'(2 * i + 1)) rdata_n[HI_W-1:0] = load_o[i][CNT_W-1:8];
      if (addr_i == A_CNT + REG_AW'(2 * i))      rdata_n = cnt_i[i][7:0];
      if (addr_i == A_CNT + REG_AW'(2 * i + 1))  rdata_n[HI_W-1:0] = cnt_i[i][CNT_W-1:8];
    end
  end

  assign rdata_o  = rdata_n;
  assign men_o    = men_q;
  assign chen_o   = chen_q;
  assign tbsel_o  = tbsel_q;
  assign irqen_o  = irqen_q;
  assign pre_rl_o = pre_q;
  assign flag_o   = flag_q;

  AST_FORCE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_FORCE) |-> (rdata_o == '0)); // R8
  AST_FLAG_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chen_q != '1) |=> ((flag_q & ~$past(chen_q)) == '0)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(timeout_i & chen_q)) |=> ((flag_q & $past(timeout_i & chen_q)) == $past(timeout_i & chen_q))); // R10
  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !men_q |-> (timeout_i == '0)); // R12
endmodule

// File: rtl/pit_timer_top.sv
module pit_timer_top
  import pit_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NCH-1:0]    irq
);
  timeunit 1ns; timeprecision 10ps;

  localparam int unsigned NUM_TB = 2;

  logic [1:0]                rst_sync_q;
  logic                      rst_core_n;
  logic                      men;
  logic [NCH-1:0]            chen, tbsel, irqen, force_s, flag, timeout;
  logic [1:0][PRE_W-1:0]     pre_rl;
  logic [NCH-1:0][CNT_W-1:0] load, cnt;
  logic [NUM_TB-1:0]         tb_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pit_regs #(.NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .rdata_o   (bus_rdata),
    .cnt_i     (cnt),
    .timeout_i (timeout),
    .men_o     (men),
    .chen_o    (chen),
    .tbsel_o   (tbsel),
    .irqen_o   (irqen),
    .pre_rl_o  (pre_rl),
    .load_o    (load),
    .force_o   (force_s),
    .flag_o    (flag)
  );

  for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
    pit_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .en_i     (men),
      .reload_i (pre_rl[t]),
      .tick_o   (tb_tick[t])
    );
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ch_tick;
    assign ch_tick = tbsel[g] ? tb_tick[1] : tb_tick[0];
    pit_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .run_i     (men & chen[g]),
      .tick_i    (ch_tick),
      .force_i   (force_s[g]),
      .load_i    (load[g]),
      .cnt_o     (cnt[g]),
      .timeout_o (timeout[g])
    );
  end

  assign irq = flag & irqen;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((irq & ~irqen) == '0)); // R11
endmodule

// File: tb/pit_timer_top_tb.sv
module pit_timer_top_tb;
  timeunit 1ns; timeprecision 10ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pit_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    bus_addr = a;
    #0.2;
    v = int'(bus_rdata);
  endtask

  task automatic rd_cnt(input int ch, output int v);
    int lo, hi;
    rd(6'h18 + 6'(2 * ch), lo);
    rd(6'h19 + 6'(2 * ch), hi);
    v = hi * 256 + lo;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    rd(6'h00, v); chk("R1", "ctrl", v, 0);
    rd(6'h02, v); chk("R1", "chen", v, 0);
    rd(6'h03, v); chk("R1", "tbsel", v, 0);
    rd(6'h05, v); chk("R1", "flags", v, 0);
    rd_cnt(0, v); chk("R1", "cnt0", v, 0);
    chk("R1", "irq", int'(irq), 0);
  endtask

  task automatic t_regs;
    int v;
    wr(6'h02, 8'hA5); rd(6'h02, v); chk("R2", "chen readback", v, 165);
    wr(6'h03, 8'h3C); rd(6'h03, v); chk("R2", "tbsel readback", v, 60);
    wr(6'h02, 8'h00); wr(6'h03, 8'h00);
    wr(6'h01, 8'hFF); rd(6'h01, v); chk("R8", "force reads zero", v, 0);
  endtask

  task automatic t_start_wrap;
    int v;
    wr(6'h07, 8'd3);
    wr(6'h00, 8'h01);
    wr(6'h08, 8'd3);
    wr(6'h02, 8'h01);
    idle(1); rd_cnt(0, v); chk("R3", "cnt after start", v, 3);
    idle(1); rd_cnt(0, v); chk("R3", "cnt after one tick", v, 2);
    idle(2); rd_cnt(0, v); chk("R4", "cnt at zero", v, 0);
    rd(6'h05, v); chk("R4", "flag before wrap", v, 0);
    idle(1); rd(6'h05, v); chk("R4", "flag after wrap", v, 1);
    rd_cnt(0, v); chk("R4", "reloaded cnt", v, 3);
    chk("R11", "irq masked", int'(irq[0]), 0);
    wr(6'h04, 8'h01);
    chk("R11", "irq enabled", int'(irq[0]), 1);
    wr(6'h02, 8'h00);
    idle(1); rd(6'h05, v); chk("R9", "flag after disable", v, 0);
    chk("R11", "irq after disable", int'(irq[0]), 0);
  endtask

  task automatic t_flags;
    int v, w;
    wr(6'h0A, 8'd0);
    wr(6'h02, 8'h02);
    idle(3); rd(6'h05, v); chk("R4", "ch1 flag", v, 2);
    wr(6'h05, 8'h02); rd(6'h05, v); chk("R10", "set wins over clear", v, 2);
    wr(6'h00, 8'h00);
    wr(6'h05, 8'h02); rd(6'h05, v); chk("R10", "w1c clears", v, 0);
    idle(5); rd(6'h05, v); chk("R12", "no flag while off", v, 0);
    wr(6'h0A, 8'd50);
    wr(6'h01, 8'h02); rd_cnt(1, v); chk("R7", "force with module off", v, 0);
    wr(6'h00, 8'h01);
    wr(6'h02, 8'h00);
    rd_cnt(1, w);
    wr(6'h01, 8'h02); rd_cnt(1, v); chk("R7", "force with channel off", v, w);
  endtask

  task automatic t_force;
    int v;
    wr(6'h02, 8'h02);
    wr(6'h0A, 8'd200);
    wr(6'h01, 8'h02); rd_cnt(1, v); chk("R6", "force loads", v, 200);
    wr(6'h01, 8'h00); rd_cnt(1, v); chk("R6", "zero force no load", v, 198);
    wr(6'h02, 8'h00);
  endtask

  task automatic t_timebase;
    int a, b, c, d;
    wr(6'h03, 8'h04);
    wr(6'h0D, 8'h10);
    wr(6'h0F, 8'h10);
    wr(6'h02, 8'h0C);
    idle(2);
    rd_cnt(2, a); rd_cnt(3, b);
    idle(40);
    rd_cnt(2, c); rd_cnt(3, d);
    chk("R5", "base1 ticks in 40", a - c, 10);
    chk("R5", "base0 ticks in 40", b - d, 40);
    wr(6'h00, 8'h00);
    rd_cnt(2, a); rd_cnt(3, b);
    idle(10);
    rd_cnt(2, c); rd_cnt(3, d);
    chk("R12", "ch2 frozen", c, a);
    chk("R12", "ch3 frozen", d, b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_start_wrap();
    t_flags();
    t_force();
    t_timebase();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule